// File: doc/BRIEF.md
# MDIO-Managed Interrupt Polarity Sublayer

This block sits between the interrupt pin of an external Ethernet PHY and a MAC whose interrupt input reacts to rising edges. Some boards wire a PHY that signals events with a falling edge. For those boards the interrupt must be inverted before it reaches the MAC. The inversion is chosen by one bit of a 16-bit configuration register. That register is reached through a Clause 22 MDIO target, which answers at its own PHY address.

Software changes the polarity with a read-modify-write of the configuration register: it reads the register, sets the polarity bit and writes the whole word back. Each write replaces all 16 bits, and every bit reads back as it was written. The raw PHY interrupt is asynchronous. It is synchronized and then passed through, or inverted. The block delivers the result as a level, and as a one-clock pulse on each rising edge of that level.

MDC and MDIO are oversampled in the system clock domain. MDC must therefore be slower than a quarter of the system clock. The MDIO pin is split into an input, an output value and an output enable. These are combined into an open-drain or tri-state pad outside the block. The MDIO link is a bit-serial management bus with its own framing. The interrupt path is a single event line. Neither carries a data stream, so the block has no valid/ready interface, and every pin is a plain control or status signal.

Top module: `irqpol_sublayer`

## Requirements
- R1: After reset the configuration register reads 0x0000. `mac_irq_level` and `mac_irq_pulse` are 0 and `mdio_oe` is 0.
- R2: Only frames whose PHY address equals `PHY_ADDR` (default 0x15) are acted on. The opcode must be write (01) or read (10). Any other PHY address, or an opcode of 00 or 11, never asserts `mdio_oe` and leaves the register unchanged.
- R3: The register sits at register address `REG_ADDR` (default 0x00). Frames at the correct PHY address but any other register address never assert `mdio_oe` and leave the register unchanged.
- R4: A matching write frame replaces all 16 bits of the register. A later read frame returns exactly the value written.
- R5: In a read frame the first turnaround bit is not driven and the second is driven 0. The 16 data bits follow MSB first, with `mdio_oe` held high. `mdio_oe` drops after the last data bit.
- R6: MDIO is sampled when MDC rises. `mdio_oe` and `mdio_o` change only after MDC falls.
- R7: A frame is recognised only after at least `PRE_MIN` (default 32) consecutive 1 bits followed by the start pattern 0,1. With 31 ones the frame is ignored.
- R8: With bit 6 of the register clear, `mac_irq_level` follows the raw PHY interrupt unchanged.
- R9: With bit 6 set, `mac_irq_level` is the inverse of the raw PHY interrupt.
- R10: Suppose `phy_irq_raw` changes before clock edge k so that the conditioned level rises. Then `mac_irq_level` and `mac_irq_pulse` both update at edge k+2, and the pulse lasts exactly one clock cycle.
- R11: A falling conditioned level produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| mdc | input | 1 | Management clock from the station manager |
| mdio_i | input | 1 | MDIO pad input value |
| mdio_o | output | 1 | MDIO value driven by the target |
| mdio_oe | output | 1 | MDIO output enable (1 = target drives) |
| phy_irq_raw | input | 1 | Asynchronous interrupt from the PHY |
| mac_irq_level | output | 1 | Synchronized, polarity-corrected interrupt level |
| mac_irq_pulse | output | 1 | One-cycle pulse on each rising edge of `mac_irq_level` |

## Verification
The bench uses the default parameters: a 5-bit address field, PHY address 0x15, register address 0x00, 16-bit data, a 32-bit minimum preamble and polarity bit 6. Because both address fields are only five bits wide, the bench sweeps every PHY address and every register address, and it checks that only the one matching pair responds. The 16-bit width allows a walking-one pattern through every data bit. The fixed preamble length allows a test one bit short of the minimum. The interrupt path is timed to the exact clock edge for both settings of the polarity bit.

// File: rtl/irqpol_pkg.sv
package irqpol_pkg;
  localparam int ADDR_W   = 5;
  localparam int OP_W     = 2;
  // start bit 1 + opcode + PHY address + register address
  localparam int HDR_BITS = 1 + OP_W + 2 * ADDR_W;

  localparam logic [OP_W-1:0] OP_WRITE = 2'b01;
  localparam logic [OP_W-1:0] OP_READ  = 2'b10;

  typedef enum logic [1:0] {
    FR_PREAMBLE,
    FR_HEADER,
    FR_TURN,
    FR_DATA
  } frame_st_e;
endpackage

// File: rtl/irqpol_sync.sv
module irqpol_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/irqpol_mdio_tgt.sv
module irqpol_mdio_tgt
  import irqpol_pkg::*;
#(
  parameter logic [ADDR_W-1:0] PHY_ADDR = 5'h15,
  parameter logic [ADDR_W-1:0] REG_ADDR = 5'h00,
  parameter int                DW       = 16,
  parameter int                PRE_MIN  = 32,
  parameter int                POL_BIT  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc_s,
  input  logic mdio_s,
  output logic mdio_o,
  output logic mdio_oe,
  output logic pol_inv
);
  localparam int CNT_MAX = (PRE_MIN > DW) ? PRE_MIN : DW;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int REG_LO  = 0;
  localparam int PHY_LO  = ADDR_W;
  localparam int OP_LO   = 2 * ADDR_W;

  frame_st_e            st;
  logic [CNT_W-1:0]     cnt;
  logic [HDR_BITS-2:0]  hdr_sr;
  logic [HDR_BITS-1:0]  hdr_nxt;
  logic [DW-1:0]        sr;
  logic [DW-1:0]        cfg_q;
  logic                 is_rd;
  logic                 mdc_d;
  logic                 mdc_rise, mdc_fall;
  logic                 pend_oe, pend_od, oe_q, od_q;
  logic                 addr_hit, hit_rd, hit_wr;

  assign mdc_rise = mdc_s & ~mdc_d;
  assign mdc_fall = ~mdc_s & mdc_d;
  assign hdr_nxt  = {hdr_sr, mdio_s};
  assign addr_hit = hdr_nxt[HDR_BITS-1]
                  && (hdr_nxt[PHY_LO +: ADDR_W] == PHY_ADDR)
                  && (hdr_nxt[REG_LO +: ADDR_W] == REG_ADDR);
  assign hit_rd   = addr_hit && (hdr_nxt[OP_LO +: OP_W] == OP_READ);
  assign hit_wr   = addr_hit && (hdr_nxt[OP_LO +: OP_W] == OP_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= FR_PREAMBLE; cnt <= '0; hdr_sr <= '0; sr <= '0; cfg_q <= '0;
      is_rd <= 1'b0; mdc_d <= 1'b0;
      pend_oe <= 1'b0; pend_od <= 1'b0; oe_q <= 1'b0; od_q <= 1'b0;
    end else begin
      mdc_d <= mdc_s;
      if (mdc_fall) begin
        oe_q <= pend_oe;
        od_q <= pend_od;
      end
      if (mdc_rise) begin
        unique case (st)
          FR_PREAMBLE: begin
            if (mdio_s) begin
              if (cnt != CNT_W'(PRE_MIN)) cnt <= cnt + 1'b1;
            end else if (cnt == CNT_W'(PRE_MIN)) begin
              st  <= FR_HEADER;
              cnt <= '0;
            end else begin
              cnt <= '0;
            end
          end
          FR_HEADER: begin
            hdr_sr <= hdr_nxt[HDR_BITS-2:0];
            cnt    <= cnt + 1'b1;
            if (cnt == CNT_W'(HDR_BITS - 1)) begin
              cnt <= '0;
              if (hit_rd) begin
                st <= FR_TURN; is_rd <= 1'b1; sr <= cfg_q;
              end else if (hit_wr) begin
                st <= FR_TURN; is_rd <= 1'b0;
              end else begin
                st <= FR_PREAMBLE;
              end
            end
          end
          FR_TURN: begin
            cnt <= cnt + 1'b1;
            if (is_rd) begin
              if (cnt == '0) begin
                pend_oe <= 1'b1;
                pend_od <= 1'b0;
              end else begin
                pend_od <= sr[DW-1];
                sr      <= sr << 1;
              end
            end
            if (cnt == CNT_W'(1)) begin
              st  <= FR_DATA;
              cnt <= '0;
            end
          end
          FR_DATA: begin
            cnt <= cnt + 1'b1;
            if (is_rd) begin
              if (cnt == CNT_W'(DW - 1)) begin
                pend_oe <= 1'b0;
              end else begin
                pend_od <= sr[DW-1];
                sr      <= sr << 1;
              end
            end else begin
              sr <= {sr[DW-2:0], mdio_s};
            end
            if (cnt == CNT_W'(DW - 1)) begin
              st  <= FR_PREAMBLE;
              cnt <= '0;
              if (!is_rd) cfg_q <= {sr[DW-2:0], mdio_s};
            end
          end
          default: st <= FR_PREAMBLE;
        endcase
      end
    end
  end

  assign mdio_o  = od_q;
  assign mdio_oe = oe_q;
  assign pol_inv = cfg_q[POL_BIT];

  AST_OE_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> is_rd);                                                    // R2
  AST_OE_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(oe_q) || $fell(oe_q)) |-> $past(mdc_fall));                  // R6
  AST_CFG_HELD_OUTSIDE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (st != FR_DATA) |=> $stable(cfg_q));                                // R3
endmodule

// File: rtl/irqpol_irq_cond.sv
module irqpol_irq_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_s,
  input  logic invert,
  output logic lvl,
  output logic pulse
);
  logic lvl_q, pul_q, cond;

  assign cond = irq_s ^ invert;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      pul_q <= 1'b0;
    end else begin
      lvl_q <= cond;
      pul_q <= cond & ~lvl_q;
    end
  end

  assign lvl   = lvl_q;
  assign pulse = pul_q;

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pul_q |=> !pul_q);                                                  // R10
  AST_PULSE_MARKS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    pul_q |-> (lvl_q && !$past(lvl_q)));                                // R10
  AST_NO_PULSE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lvl_q) |-> !pul_q);                                           // R11
endmodule

// File: rtl/irqpol_sublayer.sv
module irqpol_sublayer
  import irqpol_pkg::*;
#(
  parameter logic [ADDR_W-1:0] PHY_ADDR    = 5'h15,
  parameter logic [ADDR_W-1:0] REG_ADDR    = 5'h00,
  parameter int                DW          = 16,
  parameter int                PRE_MIN     = 32,
  parameter int                POL_BIT     = 6,
  parameter int                SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc,
  input  logic mdio_i,
  output logic mdio_o,
  output logic mdio_oe,
  input  logic phy_irq_raw,
  output logic mac_irq_level,
  output logic mac_irq_pulse
);
  logic [1:0] mgmt_s;
  logic       irq_s;
  logic       pol_inv;

  irqpol_sync #(.W(2), .STAGES(SYNC_STAGES)) u_mgmt_sync (
    .clk(clk), .rst_n(rst_n), .d({mdc, mdio_i}), .q(mgmt_s)
  );

  irqpol_sync #(.W(1), .STAGES(SYNC_STAGES)) u_irq_sync (
    .clk(clk), .rst_n(rst_n), .d(phy_irq_raw), .q(irq_s)
  );

  irqpol_mdio_tgt #(
    .PHY_ADDR(PHY_ADDR), .REG_ADDR(REG_ADDR), .DW(DW),
    .PRE_MIN(PRE_MIN), .POL_BIT(POL_BIT)
  ) u_tgt (
    .clk(clk), .rst_n(rst_n), .mdc_s(mgmt_s[1]), .mdio_s(mgmt_s[0]),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .pol_inv(pol_inv)
  );

  irqpol_irq_cond u_cond (
    .clk(clk), .rst_n(rst_n), .irq_s(irq_s), .invert(pol_inv),
    .lvl(mac_irq_level), .pulse(mac_irq_pulse)
  );
endmodule

// File: tb/tb_irqpol_sublayer.sv
`timescale 1ns/1ps
module tb_irqpol_sublayer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mdc = 1'b0;
  logic host_en = 1'b0;
  logic host_val = 1'b1;
  logic phy_irq_raw = 1'b0;
  logic mdio_o, mdio_oe, mac_irq_level, mac_irq_pulse;
  wire  mdio_line = mdio_oe ? mdio_o : (host_en ? host_val : 1'b1);

  int checks = 0;
  int errors = 0;
  int oe_seen = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irqpol_sublayer dut (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(mdio_line),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .phy_irq_raw(phy_irq_raw),
    .mac_irq_level(mac_irq_level), .mac_irq_pulse(mac_irq_pulse)
  );

  always @(negedge clk) if (mdio_oe === 1'b1) oe_seen++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one MDC period: low half then high half, 4 clocks each
  task automatic mdio_bit(input logic drv, input logic val, output logic smp, output logic oe_at);
    mdc = 1'b0; host_en = drv; host_val = val;
    repeat (4) @(negedge clk);
    smp = mdio_line; oe_at = mdio_oe;
    mdc = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic mdio_frame(input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra,
                            input logic [15:0] wd, input int pre_len,
                            output logic [15:0] rdat, output bit ta_ok, output int oe_cnt);
    logic s, o;
    logic [13:0] hdr;
    bit rd;
    rd = (op == 2'b10);
    hdr = {2'b01, op, pa, ra};
    oe_seen = 0; ta_ok = 1'b1; rdat = '0;
    mdio_bit(1'b1, 1'b0, s, o);
    for (int i = 0; i < pre_len; i++) mdio_bit(1'b1, 1'b1, s, o);
    for (int i = 13; i >= 0; i--) mdio_bit(1'b1, hdr[i], s, o);
    if (rd) begin
      mdio_bit(1'b0, 1'b1, s, o); if (o !== 1'b0) ta_ok = 1'b0;
      mdio_bit(1'b0, 1'b1, s, o); if (o !== 1'b1 || s !== 1'b0) ta_ok = 1'b0;
      for (int i = 15; i >= 0; i--) begin
        mdio_bit(1'b0, 1'b1, s, o);
        rdat[i] = s;
        if (o !== 1'b1) ta_ok = 1'b0;
      end
    end else begin
      mdio_bit(1'b1, 1'b1, s, o);
      mdio_bit(1'b1, 1'b0, s, o);
      for (int i = 15; i >= 0; i--) mdio_bit(1'b1, wd[i], s, o);
    end
    mdio_bit(1'b0, 1'b1, s, o); if (rd && o !== 1'b0) ta_ok = 1'b0;
    mdio_bit(1'b0, 1'b1, s, o);
    oe_cnt = oe_seen;
  endtask

  task automatic reg_write(input logic [15:0] v);
    logic [15:0] d; bit t; int n;
    mdio_frame(2'b01, 5'h15, 5'h00, v, 32, d, t, n);
    check(n == 0, "R4 write frame drives nothing", n, 0);
  endtask

  task automatic reg_read(output logic [15:0] v);
    bit t; int n;
    mdio_frame(2'b10, 5'h15, 5'h00, 16'h0, 32, v, t, n);
    check(t, "R5 turnaround/data drive timing", int'(t), 1);
  endtask

  // change raw irq, check level/pulse at edges k+1, k+2, k+3 (R10)
  task automatic irq_step(input logic val, input logic old_lvl, input logic new_lvl, input bit exp_pulse);
    @(negedge clk) phy_irq_raw = val;
    @(negedge clk);
    @(negedge clk);
    check(mac_irq_level == old_lvl && mac_irq_pulse == 1'b0, "R10 no change before edge k+2",
          {mac_irq_level, mac_irq_pulse}, {old_lvl, 1'b0});
    @(negedge clk);
    check(mac_irq_level == new_lvl, "R8/R9 level after edge k+2", mac_irq_level, new_lvl);
    check(mac_irq_pulse == exp_pulse, exp_pulse ? "R10 pulse at edge k+2" : "R11 no pulse on fall",
          mac_irq_pulse, exp_pulse);
    @(negedge clk);
    check(mac_irq_pulse == 1'b0, "R10 pulse lasts one cycle", mac_irq_pulse, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, d;
    bit t;
    int n;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(mac_irq_level == 0 && mac_irq_pulse == 0 && mdio_oe == 0, "R1 outputs after reset",
          {mac_irq_level, mac_irq_pulse, mdio_oe}, 0);
    reg_read(v);
    check(v == 16'h0000, "R1 register reset value", v, 0);

    // R4: walking one and fixed patterns
    for (int i = 0; i < 16; i++) begin
      reg_write(16'h1 << i);
      reg_read(v);
      check(v == (16'h1 << i), "R4 walking-one readback", v, 16'h1 << i);
    end
    foreach (d[i]) ;
    for (int k = 0; k < 4; k++) begin
      d = (k == 0) ? 16'hA5C3 : (k == 1) ? 16'h5A3C : (k == 2) ? 16'hFFFF : 16'h0000;
      reg_write(d);
      reg_read(v);
      check(v == d, "R4 pattern readback", v, d);
    end

    // R2: every other PHY address
    reg_write(16'hBEEF);
    for (int pa = 0; pa < 32; pa++) begin
      if (pa == 5'h15) continue;
      mdio_frame(2'b01, 5'(pa), 5'h00, 16'h1234, 32, v, t, n);
      mdio_frame(2'b10, 5'(pa), 5'h00, 16'h0, 32, v, t, n);
      check(n == 0, "R2 foreign PHY address read not driven", n, 0);
    end
    reg_read(v);
    check(v == 16'hBEEF, "R2 register unchanged by foreign PHY address", v, 16'hBEEF);

    // R3: every other register address
    for (int ra = 1; ra < 32; ra++) begin
      mdio_frame(2'b01, 5'h15, 5'(ra), 16'h4321, 32, v, t, n);
      mdio_frame(2'b10, 5'h15, 5'(ra), 16'h0, 32, v, t, n);
      check(n == 0, "R3 other register address read not driven", n, 0);
    end
    reg_read(v);
    check(v == 16'hBEEF, "R3 register unchanged by other register address", v, 16'hBEEF);

    // R2: invalid opcodes 00 and 11
    mdio_frame(2'b00, 5'h15, 5'h00, 16'h0F0F, 32, v, t, n);
    check(n == 0, "R2 opcode 00 not driven", n, 0);
    mdio_frame(2'b11, 5'h15, 5'h00, 16'h0F0F, 32, v, t, n);
    check(n == 0, "R2 opcode 11 not driven", n, 0);
    reg_read(v);
    check(v == 16'hBEEF, "R2 register unchanged by bad opcode", v, 16'hBEEF);

    // R7: preamble one bit short
    mdio_frame(2'b01, 5'h15, 5'h00, 16'h7777, 31, v, t, n);
    reg_read(v);
    check(v == 16'hBEEF, "R7 short preamble ignored", v, 16'hBEEF);
    mdio_frame(2'b10, 5'h15, 5'h00, 16'h0, 31, v, t, n);
    check(n == 0, "R7 short preamble read not driven", n, 0);

    // R8: pass-through with bit 6 clear
    reg_write(16'h0000);
    repeat (4) @(negedge clk);
    check(mac_irq_level == 1'b0, "R8 level idle", mac_irq_level, 0);
    irq_step(1'b1, 1'b0, 1'b1, 1'b1);
    irq_step(1'b0, 1'b1, 1'b0, 1'b0);

    // R9: read-modify-write sets bit 6, other bits kept
    reg_write(16'h8001);
    reg_read(v);
    reg_write(v | 16'h0040);
    reg_read(v);
    check(v == 16'h8041, "R9 read-modify-write keeps other bits", v, 16'h8041);
    repeat (6) @(negedge clk);
    check(mac_irq_level == 1'b1, "R9 inverted idle level", mac_irq_level, 1);
    irq_step(1'b1, 1'b1, 1'b0, 1'b0);
    irq_step(1'b0, 1'b0, 1'b1, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule